// File: doc/BRIEF.md
# ADC Scan Sequencer

This block steps an analog-to-digital converter through a programmed, ordered list of ranks. Each rank names one input channel and its own sampling time. For each rank the sequencer holds the channel select steady through a sampling window, fires a one-cycle conversion start, and waits for the converter's done strobe and 12-bit result. It then overwrites a single 16-bit data register with that result. Because every result replaces the previous one, the block can raise a one-cycle transfer request after each conversion, so that a DMA engine moves the value out before the next result lands.

A scan runs one pass or loops forever, chosen by a mode input. The block can start a scan only after a two-step calibration: a reset step, then a calibration run. A software start that arrives before calibration has finished is held until it finishes. An end-of-sequence flag marks each completed pass. Configuration (sequence length, rank channels, rank sample times) comes in on plain input vectors and must stay stable while a scan runs.

Top module: `adc_scan_seq`

## Requirements
- R1: Conversions follow rank order 1, 2, … up to the sequence length. `conv_ch_o` carries the channel of the current rank, where rank k (counting from 0) is taken from bits [k*4 +: 4] of `rank_ch_i`. A length of 0 behaves as 1, and a length above 8 behaves as 8.
- R2: Each rank samples for (sample time + 1) cycles with `sample_o` high, where rank k's sample time is bits [k*8 +: 8] of `rank_smp_i`. Sampling is followed by a one-cycle `conv_start_o` pulse with `sample_o` low.
- R3: On the cycle after `conv_done_i`, `data_o` holds `conv_res_i` right-aligned with bits [15:12] zero, and `eoc_o` pulses for one cycle.
- R4: When `dma_en_i` is high, `dma_req_o` pulses together with each `eoc_o`. When it is low, no request is issued and conversions still proceed.
- R5: In single-pass mode (`cont_i` = 0) the scan stops and `busy_o` drops after the last rank. In continuous mode it wraps to rank 1 with no new start.
- R6: `eos_o` sets together with the last rank's `eoc_o` in every pass and stays set until `eos_clr_i`.
- R7: `cal_rst_i` runs the reset step, with `cal_rst_busy_o` high for 4 cycles. `cal_i` runs the calibration step, with `cal_busy_o` high for 20 cycles, only if a reset step has completed since the last calibration run, and otherwise it is ignored. `cal_ok_o` sets when the calibration step ends and is low after reset.
- R8: A scan starts only while `cal_ok_o` is high and no calibration step is active. A start received earlier is held and launches as soon as calibration completes.
- R9: Driving `en_i` low aborts a scan, drops a held start and clears `cal_ok_o`. `start_i` is ignored while `en_i` is low.
- R10: `start_i`, `cal_rst_i` and `cal_i` are ignored while a scan is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Converter enable |
| cont_i | input | 1 | 1 = continuous scanning, 0 = single pass |
| dma_en_i | input | 1 | Enables transfer requests |
| seq_len_i | input | 4 | Number of ranks in the scan |
| rank_ch_i | input | 32 | Channel per rank, 4 bits each, rank 0 at the LSBs |
| rank_smp_i | input | 64 | Sample time per rank, 8 bits each, rank 0 at the LSBs |
| start_i | input | 1 | Software start pulse |
| cal_rst_i | input | 1 | Reset-calibration command pulse |
| cal_i | input | 1 | Calibration command pulse |
| eos_clr_i | input | 1 | Clears the end-of-sequence flag |
| conv_ch_o | output | 4 | Channel select to the converter |
| conv_start_o | output | 1 | Conversion start pulse |
| conv_done_i | input | 1 | Conversion done strobe |
| conv_res_i | input | 12 | Conversion result |
| sample_o | output | 1 | Sampling window active |
| data_o | output | 16 | Data register |
| eoc_o | output | 1 | End-of-conversion pulse |
| dma_req_o | output | 1 | Transfer request pulse |
| eos_o | output | 1 | End-of-sequence flag |
| busy_o | output | 1 | Scan in progress |
| cal_rst_busy_o | output | 1 | Reset-calibration step active |
| cal_busy_o | output | 1 | Calibration step active |
| cal_ok_o | output | 1 | Calibration complete |

## Verification
The assertions assume that the converter returns exactly one `conv_done_i` per `conv_start_o`, never in the same cycle as the start. They also assume that the sequence length and rank tables do not change while `busy_o` is high. The bench's converter model answers every start after three cycles with a result that encodes the channel and a running tag. The bench changes configuration only while the block is idle, or after pulling `en_i` low. A done strobe that arrives after an abort reaches an idle sequencer and is dropped.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_SAMPLE, SQ_CONV} sq_state_e;
  typedef enum logic [1:0] {CL_IDLE, CL_RESET, CL_RUN}   cl_state_e;
endpackage

// File: rtl/adc_scan_cal.sv
module adc_scan_cal
  import adc_scan_pkg::*;
#(
  parameter int RST_CYC = 4,
  parameter int RUN_CYC = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic hold_i,
  input  logic cal_rst_i,
  input  logic cal_i,
  output logic rst_busy_o,
  output logic run_busy_o,
  output logic cal_ok_o
);
  localparam int MAXC = (RST_CYC > RUN_CYC) ? RST_CYC : RUN_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  cl_state_e       state_q;
  logic [CW-1:0]   cnt_q;
  logic            rst_done_q;
  logic            ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= CL_IDLE;
      cnt_q      <= '0;
      rst_done_q <= 1'b0;
      ok_q       <= 1'b0;
    end else if (!en_i) begin
      state_q    <= CL_IDLE;
      cnt_q      <= '0;
      rst_done_q <= 1'b0;
      ok_q       <= 1'b0;
    end else begin
      unique case (state_q)
        CL_IDLE: begin
          if (cal_rst_i && !hold_i) begin
            state_q    <= CL_RESET;
            cnt_q      <= CW'(RST_CYC - 1);
            ok_q       <= 1'b0;
            rst_done_q <= 1'b0;
          end else if (cal_i && rst_done_q && !hold_i) begin
            state_q <= CL_RUN;
            cnt_q   <= CW'(RUN_CYC - 1);
          end
        end
        CL_RESET: begin
          if (cnt_q == '0) begin
            state_q    <= CL_IDLE;
            rst_done_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        CL_RUN: begin
          if (cnt_q == '0) begin
            state_q    <= CL_IDLE;
            ok_q       <= 1'b1;
            rst_done_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= CL_IDLE;
      endcase
    end
  end

  assign rst_busy_o = (state_q == CL_RESET);
  assign run_busy_o = (state_q == CL_RUN);
  assign cal_ok_o   = ok_q;

  // R7: calibration run only after a completed reset step
  a_r7_run_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_busy_o) |-> $past(rst_done_q));
  // R7: ok only at the end of a calibration run
  a_r7_ok_after_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cal_ok_o) |-> $past(run_busy_o));
  // R10: no calibration command accepted during a scan
  a_r10_cal_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(hold_i) && !$past(rst_busy_o) && !$past(run_busy_o) |-> !rst_busy_o && !run_busy_o);
endmodule

// File: rtl/adc_scan_core.sv
module adc_scan_core
  import adc_scan_pkg::*;
#(
  parameter int MAX_RANK = 8,
  parameter int CH_W     = 4,
  parameter int SMP_W    = 8,
  localparam int RANK_W  = (MAX_RANK > 1) ? $clog2(MAX_RANK) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      en_i,
  input  logic                      cont_i,
  input  logic [RANK_W-1:0]         last_idx_i,
  input  logic [MAX_RANK*CH_W-1:0]  ch_flat_i,
  input  logic [MAX_RANK*SMP_W-1:0] smp_flat_i,
  input  logic                      go_i,
  input  logic                      conv_done_i,
  output logic [CH_W-1:0]           conv_ch_o,
  output logic                      conv_start_o,
  output logic                      sample_o,
  output logic                      busy_o,
  output logic                      done_o,
  output logic                      last_o
);
  logic [CH_W-1:0]  ch_a  [MAX_RANK];
  logic [SMP_W-1:0] smp_a [MAX_RANK];

  for (genvar g = 0; g < MAX_RANK; g++) begin : g_unpack
    assign ch_a[g]  = ch_flat_i[g*CH_W +: CH_W];
    assign smp_a[g] = smp_flat_i[g*SMP_W +: SMP_W];
  end

  sq_state_e          state_q;
  logic [RANK_W-1:0]  rank_q;
  logic [SMP_W-1:0]   cnt_q;
  logic               start_q;
  logic [RANK_W-1:0]  nxt_rank;

  assign last_o   = (rank_q == last_idx_i);
  assign nxt_rank = last_o ? '0 : rank_q + 1'b1;
  assign done_o   = en_i && (state_q == SQ_CONV) && conv_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      rank_q  <= '0;
      cnt_q   <= '0;
      start_q <= 1'b0;
    end else if (!en_i) begin
      state_q <= SQ_IDLE;
      rank_q  <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      unique case (state_q)
        SQ_IDLE: begin
          if (go_i) begin
            state_q <= SQ_SAMPLE;
            rank_q  <= '0;
            cnt_q   <= smp_a[0];
          end
        end
        SQ_SAMPLE: begin
          if (cnt_q == '0) begin
            state_q <= SQ_CONV;
            start_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        SQ_CONV: begin
          if (conv_done_i) begin
            if (last_o && !cont_i) begin
              state_q <= SQ_IDLE;
              rank_q  <= '0;
            end else begin
              state_q <= SQ_SAMPLE;
              rank_q  <= nxt_rank;
              cnt_q   <= smp_a[nxt_rank];
            end
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign conv_ch_o    = ch_a[rank_q];
  assign conv_start_o = start_q;
  assign sample_o     = (state_q == SQ_SAMPLE);
  assign busy_o       = (state_q != SQ_IDLE);

  // R2: start pulse closes a sampling window
  a_r2_start_after_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> !sample_o && $past(sample_o));
  // R1: rank never passes the programmed length
  a_r1_rank_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> rank_q <= last_idx_i);
  // R5: single pass ends after last rank
  a_r5_single_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && last_o && !cont_i |=> !busy_o);
  // R5: continuous mode wraps to the first rank
  a_r5_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && last_o && cont_i |=> !en_i || (sample_o && rank_q == '0));
endmodule

// File: rtl/adc_scan_out.sv
module adc_scan_out #(
  parameter int RES_W  = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic              last_i,
  input  logic [RES_W-1:0]  res_i,
  input  logic              dma_en_i,
  input  logic              eos_clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              eoc_o,
  output logic              dma_req_o,
  output logic              eos_o
);
  localparam int PAD_W = DATA_W - RES_W;

  logic [DATA_W-1:0] data_q;
  logic              eoc_q, dma_q, eos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      eoc_q  <= 1'b0;
      dma_q  <= 1'b0;
      eos_q  <= 1'b0;
    end else begin
      eoc_q <= done_i;
      dma_q <= done_i && dma_en_i;
      if (done_i) data_q <= {{PAD_W{1'b0}}, res_i};
      // set wins over clear
      if (done_i && last_i) eos_q <= 1'b1;
      else if (eos_clr_i)   eos_q <= 1'b0;
    end
  end

  assign data_o    = data_q;
  assign eoc_o     = eoc_q;
  assign dma_req_o = dma_q;
  assign eos_o     = eos_q;

  // R3: register holds the last result, zero-extended
  a_r3_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |-> data_o[RES_W-1:0] == $past(res_i) && data_o[DATA_W-1:RES_W] == '0);
  // R4: request only with a conversion and an enabled request path
  a_r4_dma_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> eoc_o && $past(dma_en_i));
  // R6: end-of-sequence rises only with a conversion end
  a_r6_eos_with_eoc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eos_o) |-> eoc_o);
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int MAX_RANK = 8,
  parameter int CH_W     = 4,
  parameter int SMP_W    = 8,
  parameter int RES_W    = 12,
  parameter int DATA_W   = 16,
  parameter int CAL_RST_CYC = 4,
  parameter int CAL_CYC     = 20,
  localparam int LEN_W  = $clog2(MAX_RANK + 1),
  localparam int RANK_W = (MAX_RANK > 1) ? $clog2(MAX_RANK) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      en_i,
  input  logic                      cont_i,
  input  logic                      dma_en_i,
  input  logic [LEN_W-1:0]          seq_len_i,
  input  logic [MAX_RANK*CH_W-1:0]  rank_ch_i,
  input  logic [MAX_RANK*SMP_W-1:0] rank_smp_i,
  input  logic                      start_i,
  input  logic                      cal_rst_i,
  input  logic                      cal_i,
  input  logic                      eos_clr_i,
  output logic [CH_W-1:0]           conv_ch_o,
  output logic                      conv_start_o,
  input  logic                      conv_done_i,
  input  logic [RES_W-1:0]          conv_res_i,
  output logic                      sample_o,
  output logic [DATA_W-1:0]         data_o,
  output logic                      eoc_o,
  output logic                      dma_req_o,
  output logic                      eos_o,
  output logic                      busy_o,
  output logic                      cal_rst_busy_o,
  output logic                      cal_busy_o,
  output logic                      cal_ok_o
);
  logic [LEN_W-1:0]  len_c;
  logic [RANK_W-1:0] last_idx;
  logic              pend_q, launch;
  logic              done, last;

  always_comb begin
    if (seq_len_i == '0)                      len_c = LEN_W'(1);
    else if (seq_len_i > LEN_W'(MAX_RANK))    len_c = LEN_W'(MAX_RANK);
    else                                      len_c = seq_len_i;
  end
  assign last_idx = RANK_W'(len_c - 1'b1);

  assign launch = pend_q && cal_ok_o && !cal_rst_busy_o && !cal_busy_o && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   pend_q <= 1'b0;
    else if (!en_i)                pend_q <= 1'b0;
    else if (launch)               pend_q <= 1'b0;
    else if (start_i && !busy_o)   pend_q <= 1'b1;
  end

  adc_scan_cal #(
    .RST_CYC (CAL_RST_CYC),
    .RUN_CYC (CAL_CYC)
  ) u_cal (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .hold_i     (busy_o),
    .cal_rst_i  (cal_rst_i),
    .cal_i      (cal_i),
    .rst_busy_o (cal_rst_busy_o),
    .run_busy_o (cal_busy_o),
    .cal_ok_o   (cal_ok_o)
  );

  adc_scan_core #(
    .MAX_RANK (MAX_RANK),
    .CH_W     (CH_W),
    .SMP_W    (SMP_W)
  ) u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .cont_i       (cont_i),
    .last_idx_i   (last_idx),
    .ch_flat_i    (rank_ch_i),
    .smp_flat_i   (rank_smp_i),
    .go_i         (launch),
    .conv_done_i  (conv_done_i),
    .conv_ch_o    (conv_ch_o),
    .conv_start_o (conv_start_o),
    .sample_o     (sample_o),
    .busy_o       (busy_o),
    .done_o       (done),
    .last_o       (last)
  );

  adc_scan_out #(
    .RES_W  (RES_W),
    .DATA_W (DATA_W)
  ) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .done_i    (done),
    .last_i    (last),
    .res_i     (conv_res_i),
    .dma_en_i  (dma_en_i),
    .eos_clr_i (eos_clr_i),
    .data_o    (data_o),
    .eoc_o     (eoc_o),
    .dma_req_o (dma_req_o),
    .eos_o     (eos_o)
  );

  // R8: a scan only begins once calibrated
  a_r8_cal_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(cal_ok_o) && $past(en_i));
  // R9: disable aborts the scan and drops calibration
  a_r9_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !busy_o && !cal_ok_o);
  // R8: no sampling while a calibration step runs
  a_r8_no_scan_in_cal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cal_rst_busy_o || cal_busy_o) |-> !busy_o);
endmodule

// File: tb/adc_scan_seq_tb.sv
module adc_scan_seq_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0, cont_i = 1'b0, dma_en_i = 1'b0;
  logic [3:0]  seq_len_i = '0;
  logic [31:0] rank_ch_i = '0;
  logic [63:0] rank_smp_i = '0;
  logic        start_i = 1'b0, cal_rst_i = 1'b0, cal_i = 1'b0, eos_clr_i = 1'b0;
  logic [3:0]  conv_ch_o;
  logic        conv_start_o;
  logic        conv_done_i;
  logic [11:0] conv_res_i;
  logic        sample_o;
  logic [15:0] data_o;
  logic        eoc_o, dma_req_o, eos_o, busy_o;
  logic        cal_rst_busy_o, cal_busy_o, cal_ok_o;

  always #5 clk_i = ~clk_i;

  adc_scan_seq u_dut (
    .clk_i, .rst_ni, .en_i, .cont_i, .dma_en_i, .seq_len_i, .rank_ch_i, .rank_smp_i,
    .start_i, .cal_rst_i, .cal_i, .eos_clr_i, .conv_ch_o, .conv_start_o,
    .conv_done_i, .conv_res_i, .sample_o, .data_o, .eoc_o, .dma_req_o, .eos_o,
    .busy_o, .cal_rst_busy_o, .cal_busy_o, .cal_ok_o
  );

  // converter model: done three cycles after start, result = {channel, tag}
  logic [1:0] m_cnt;
  logic       m_act;
  logic [3:0] m_ch;
  logic [7:0] m_tag;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt <= '0; m_act <= 1'b0; m_ch <= '0; m_tag <= 8'h30;
      conv_done_i <= 1'b0; conv_res_i <= '0;
    end else begin
      conv_done_i <= 1'b0;
      if (conv_start_o) begin
        m_act <= 1'b1; m_cnt <= 2'd2; m_ch <= conv_ch_o;
      end else if (m_act) begin
        if (m_cnt == 2'd0) begin
          m_act <= 1'b0; conv_done_i <= 1'b1;
          conv_res_i <= {m_ch, m_tag}; m_tag <= m_tag + 8'd1;
        end else m_cnt <= m_cnt - 2'd1;
      end
    end
  end

  // event monitor
  int n_st, n_smp, n_eoc, n_res, dma_n, stray, smp_run;
  bit rst_seen;
  logic [3:0]  ch_log  [32];
  int          smp_log [32];
  logic [15:0] dat_log [32];
  logic [11:0] res_log [32];
  always @(negedge clk_i) begin
    if (sample_o) smp_run++;
    else if (smp_run > 0) begin
      if (n_smp < 32) smp_log[n_smp] = smp_run;
      n_smp++; smp_run = 0;
    end
    if (conv_start_o) begin if (n_st < 32) ch_log[n_st] = conv_ch_o; n_st++; end
    if (conv_done_i)  begin if (n_res < 32) res_log[n_res] = conv_res_i; n_res++; end
    if (eoc_o)        begin if (n_eoc < 32) dat_log[n_eoc] = data_o; n_eoc++; end
    if (dma_req_o) dma_n++;
    if (dma_req_o && !eoc_o) stray++;
    if (cal_rst_busy_o) rst_seen = 1'b1;
  end

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clr_logs();
    n_st = 0; n_smp = 0; n_eoc = 0; n_res = 0; dma_n = 0; stray = 0; smp_run = 0; rst_seen = 1'b0;
  endtask

  task automatic pulse_start();  @(negedge clk_i) start_i = 1'b1;   @(negedge clk_i) start_i = 1'b0;   endtask
  task automatic pulse_calrst(); @(negedge clk_i) cal_rst_i = 1'b1; @(negedge clk_i) cal_rst_i = 1'b0; endtask
  task automatic pulse_cal();    @(negedge clk_i) cal_i = 1'b1;     @(negedge clk_i) cal_i = 1'b0;     endtask

  task automatic wait_busy(input bit val, input int lim, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk_i);
      if (busy_o == val) begin ok = 1'b1; break; end
    end
  endtask

  task automatic do_cal();
    pulse_calrst();
    while (cal_rst_busy_o) @(negedge clk_i);
    pulse_cal();
    while (cal_busy_o) @(negedge clk_i);
  endtask

  task automatic finish_pass(input int n, input logic [31:0] ch, input logic [63:0] smp, input bit dma);
    bit ok;
    int bad;
    wait_busy(1'b0, 3000, ok);
    repeat (2) @(negedge clk_i);
    chk(ok, "R5", "single pass ended", int'(busy_o), 0);
    chk(n_st == n, "R1", "conversion count", n_st, n);
    bad = 0;
    for (int k = 0; k < n && k < 32; k++) if (ch_log[k] != ch[k*4 +: 4]) bad++;
    chk(bad == 0, "R1", "rank order mismatches", bad, 0);
    bad = 0;
    for (int k = 0; k < n && k < 32; k++) if (smp_log[k] != int'(smp[k*8 +: 8]) + 1) bad++;
    chk(n_smp == n && bad == 0, "R2", "sample window mismatches", bad + n_smp, n);
    bad = 0;
    for (int k = 0; k < n_eoc && k < 32; k++)
      if (dat_log[k] !== {4'h0, res_log[k]} || res_log[k][11:8] != ch[k*4 +: 4]) bad++;
    chk(n_eoc == n && bad == 0, "R3", "data register mismatches", bad + n_eoc, n);
    chk(dma_n == (dma ? n : 0) && stray == 0, "R4", "transfer requests", dma_n, dma ? n : 0);
    chk(eos_o == 1'b1, "R6", "eos after pass", int'(eos_o), 1);
    @(negedge clk_i) eos_clr_i = 1'b1;
    @(negedge clk_i) eos_clr_i = 1'b0;
    chk(eos_o == 1'b0, "R6", "eos cleared", int'(eos_o), 0);
  endtask

  task automatic run_pass(input logic [3:0] len, input int n, input logic [31:0] ch,
                          input logic [63:0] smp, input bit dma);
    bit ok;
    @(negedge clk_i);
    seq_len_i = len; rank_ch_i = ch; rank_smp_i = smp; dma_en_i = dma;
    clr_logs();
    pulse_start();
    wait_busy(1'b1, 20, ok);
    chk(ok, "R8", "scan launched", int'(busy_o), 1);
    finish_pass(n, ch, smp, dma);
  endtask

  // stimulus table: length, rank channels, rank sample times, request enable
  localparam int NV = 4;
  localparam logic [3:0]  V_LEN [NV] = '{4'd4, 4'd3, 4'd8, 4'd1};
  localparam logic [31:0] V_CH  [NV] = '{32'h0000_3210, 32'h0000_0F49, 32'h0123_4567, 32'h0000_000C};
  localparam logic [63:0] V_SMP [NV] = '{64'h0000_0000_0105_0002, 64'h0,
                                         64'h0302_0100_0403_0201, 64'h0000_0000_0000_0007};
  localparam bit          V_DMA [NV] = '{1'b1, 1'b0, 1'b1, 1'b1};

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit ok;
    int cnt;
    clr_logs();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // reset state
    chk(cal_ok_o == 0 && cal_rst_busy_o == 0 && cal_busy_o == 0, "R7", "calibration reset state", int'(cal_ok_o), 0);
    chk(data_o == 16'h0 && eoc_o == 0 && dma_req_o == 0 && eos_o == 0 && busy_o == 0, "R3", "output reset state", int'(data_o), 0);

    en_i = 1'b1;
    seq_len_i = V_LEN[0]; rank_ch_i = V_CH[0]; rank_smp_i = V_SMP[0]; dma_en_i = V_DMA[0];

    // calibration step without a prior reset step is ignored
    pulse_cal();
    repeat (25) @(negedge clk_i);
    chk(rst_seen == 0 && cal_ok_o == 0 && cal_busy_o == 0, "R7", "cal without reset ignored", int'(cal_ok_o), 0);

    // reset step, with a start arriving during it (held)
    clr_logs();
    pulse_calrst();
    cnt = 0;
    while (cal_rst_busy_o) begin
      cnt++;
      start_i = (cnt == 1);
      @(negedge clk_i);
    end
    start_i = 1'b0;
    chk(cnt == 4, "R7", "reset step length", cnt, 4);
    repeat (5) @(negedge clk_i);
    chk(busy_o == 0, "R8", "start held while uncalibrated", int'(busy_o), 0);
    pulse_cal();
    cnt = 0;
    while (cal_busy_o) begin
      cnt++;
      if (busy_o) ok = 1'b0;
      @(negedge clk_i);
    end
    chk(cnt == 20, "R7", "calibration step length", cnt, 20);
    chk(cal_ok_o == 1, "R7", "calibrated flag", int'(cal_ok_o), 1);
    wait_busy(1'b1, 3, ok);
    chk(ok, "R8", "held start launches after calibration", int'(busy_o), 1);
    finish_pass(4, V_CH[0], V_SMP[0], 1'b1);

    // table walk
    for (int v = 0; v < NV; v++)
      run_pass(V_LEN[v], int'(V_LEN[v]), V_CH[v], V_SMP[v], V_DMA[v]);

    // length clamping
    run_pass(4'd0,  1, V_CH[0], V_SMP[0], 1'b1);   // R1: zero behaves as one
    run_pass(4'd15, 8, V_CH[2], V_SMP[2], 1'b0);   // R1: above eight behaves as eight

    // commands during a scan are ignored
    @(negedge clk_i);
    seq_len_i = V_LEN[2]; rank_ch_i = V_CH[2]; rank_smp_i = V_SMP[2]; dma_en_i = 1'b1;
    clr_logs();
    pulse_start();
    wait_busy(1'b1, 20, ok);
    repeat (10) @(negedge clk_i);
    pulse_start();
    pulse_calrst();
    finish_pass(8, V_CH[2], V_SMP[2], 1'b1);
    repeat (20) @(negedge clk_i);
    chk(busy_o == 0, "R10", "start during scan ignored", int'(busy_o), 0);
    chk(rst_seen == 0 && cal_ok_o == 1, "R10", "reset-cal during scan ignored", int'(rst_seen), 0);

    // continuous scanning wraps
    @(negedge clk_i);
    seq_len_i = V_LEN[1]; rank_ch_i = V_CH[1]; rank_smp_i = V_SMP[1]; dma_en_i = 1'b0; cont_i = 1'b1;
    clr_logs();
    pulse_start();
    cnt = 0;
    while (n_st < 7 && cnt < 500) begin cnt++; @(negedge clk_i); end
    begin
      int bad = 0;
      for (int k = 0; k < 7; k++) if (ch_log[k] != V_CH[1][(k % 3)*4 +: 4]) bad++;
      chk(n_st >= 7 && bad == 0, "R5", "continuous wrap order", bad, 0);
    end
    chk(busy_o == 1, "R5", "continuous still running", int'(busy_o), 1);
    chk(eos_o == 1, "R6", "eos set in continuous mode", int'(eos_o), 1);
    chk(n_eoc >= 6 && dma_n == 0, "R4", "no requests with enable low", dma_n, 0);

    // disable aborts
    @(negedge clk_i) en_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk(busy_o == 0 && cal_ok_o == 0, "R9", "disable aborts and uncalibrates", int'(busy_o) + int'(cal_ok_o), 0);
    cont_i = 1'b0;
    pulse_start();
    @(negedge clk_i) en_i = 1'b1;
    do_cal();
    repeat (10) @(negedge clk_i);
    chk(cal_ok_o == 1 && busy_o == 0, "R9", "start while disabled ignored", int'(busy_o), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule